// File: doc/BRIEF.md
# Multicycle Program Counter Update Unit

This unit holds the program counter of a multicycle processor and decides, cycle by cycle, whether it changes and what its new value is. A two-bit source code chooses among three candidates: the ALU result (the sequential address during fetch), a branch target held in a dedicated register, and a jump address built from the current PC and the target field of the instruction word.

The branch target register is loaded from the ALU result on its own strobe, normally during decode. It keeps that value until the branch resolves. The PC can be written in two ways. An unconditional strobe always writes it. A conditional strobe writes it only when the ALU zero flag is set. When neither applies, the PC keeps its value.

All pins are plain control and data levels sampled at the rising clock edge. There is no stream handshake, because the sequencer owning the strobes decides every cycle what happens.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both the PC and the branch target register to 0 at the next rising edge. After reset, a PC load with source 01 gives 0.
- R2: With `pc_wr` high and `pc_sel` = 00, the PC takes `alu_res` at the next edge.
- R3: With `tgt_wr` high, the target register takes `alu_res`. Without `tgt_wr` it keeps its value. A PC load with `pc_sel` = 01 copies the held target into the PC.
- R4: With `pc_sel` = 10, a PC load gives {old PC[31:28], `jmp_field`[25:0], 2'b00}.
- R5: `pc_sel` = 11 behaves exactly like 00: a PC load takes `alu_res`.
- R6: With `pc_wr_zero` high and `alu_zero` = 1, the PC loads the selected source even when `pc_wr` is low.
- R7: With `pc_wr_zero` high, `alu_zero` = 0 and `pc_wr` low, the PC is unchanged.
- R8: With both `pc_wr` and `pc_wr_zero` low, the PC is unchanged whatever the data and select inputs are.
- R9: `pc_wr` high loads the PC whatever the value of `alu_zero`.
- R10: When `tgt_wr` and a PC load with source 01 happen in the same cycle, the PC gets the target value held before that edge. The new target shows up on a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 32 | ALU result: sequential address or computed branch target |
| alu_zero | input | 1 | ALU zero flag, qualifies conditional writes |
| jmp_field | input | 26 | Word-address field of a jump instruction |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_zero | input | 1 | PC write strobe qualified by `alu_zero` |
| tgt_wr | input | 1 | Branch target register load strobe |
| pc_sel | input | 2 | Source code: 00 ALU, 01 target, 10 jump, 11 ALU |
| pc_q | output | 32 | Current program counter |

## Verification
Every cycle, the in-line assertions check several behaviours. They check that an unqualified cycle or a conditional write with a clear zero flag leaves the PC stable. They check that an unconditional load with source 00, 11 or 10 produces the ALU result or the jump concatenation. They check that each storage register follows its enable. The bench scenarios check the rest: the reset values, the target register's value as seen through a source-01 load, and the same-cycle ordering of a target write and a target-sourced PC load. Together with mixed strobe patterns, these are compared against an independent model through a scoreboard.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_ALU  = 2'b00,
    SRC_TGT  = 2'b01,
    SRC_JMP  = 2'b10,
    SRC_SPR  = 2'b11
  } pc_src_e;
endpackage

// File: rtl/pcu_hold_reg.sv
module pcu_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R8 / R3: register holds without enable, follows d with it
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == $past(d)));
endmodule

// File: rtl/pcu_jump_form.sv
module pcu_jump_form #(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26
) (
  input  logic [XLEN-1:0]    pc,
  input  logic [FIELD_W-1:0] field,
  output logic [XLEN-1:0]    jaddr
);
  localparam int SEG_W = XLEN - FIELD_W - 2;

  generate
    if (SEG_W > 0) begin : g_seg
      assign jaddr = {pc[XLEN-1 -: SEG_W], field, 2'b00};
    end else begin : g_noseg
      assign jaddr = {field[XLEN-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/pcu_src_sel.sv
module pcu_src_sel
  import pcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  pc_src_e         sel,
  input  logic [XLEN-1:0] alu,
  input  logic [XLEN-1:0] tgt,
  input  logic [XLEN-1:0] jaddr,
  input  logic            wr,
  input  logic            wr_zero,
  input  logic            zero,
  output logic [XLEN-1:0] nxt,
  output logic            load
);
  always_comb begin
    unique case (sel)
      SRC_TGT: nxt = tgt;
      SRC_JMP: nxt = jaddr;
      default: nxt = alu;
    endcase
  end

  assign load = wr | (wr_zero & zero);
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    alu_res,
  input  logic               alu_zero,
  input  logic [FIELD_W-1:0] jmp_field,
  input  logic               pc_wr,
  input  logic               pc_wr_zero,
  input  logic               tgt_wr,
  input  logic [1:0]         pc_sel,
  output logic [XLEN-1:0]    pc_q
);
  localparam int SEG_W = XLEN - FIELD_W - 2;

  logic [XLEN-1:0] tgt_q;
  logic [XLEN-1:0] jaddr;
  logic [XLEN-1:0] nxt;
  logic            load;

  pcu_hold_reg #(.W(XLEN)) u_tgt (
    .clk(clk), .rst(rst), .en(tgt_wr), .d(alu_res), .q(tgt_q)
  );

  pcu_jump_form #(.XLEN(XLEN), .FIELD_W(FIELD_W)) u_jmp (
    .pc(pc_q), .field(jmp_field), .jaddr(jaddr)
  );

  pcu_src_sel #(.XLEN(XLEN)) u_sel (
    .sel(pc_src_e'(pc_sel)), .alu(alu_res), .tgt(tgt_q), .jaddr(jaddr),
    .wr(pc_wr), .wr_zero(pc_wr_zero), .zero(alu_zero),
    .nxt(nxt), .load(load)
  );

  pcu_hold_reg #(.W(XLEN)) u_pc (
    .clk(clk), .rst(rst), .en(load), .d(nxt), .q(pc_q)
  );

  assert_alu_src_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b00) |=> (pc_q == $past(alu_res)));
  assert_spare_src_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b11) |=> (pc_q == $past(alu_res)));
  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b10) |=>
      (pc_q == {$past(pc_q[XLEN-1 -: SEG_W]), $past(jmp_field), 2'b00}));
  assert_cond_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_zero && !alu_zero && !pc_wr) |=> $stable(pc_q));
  assert_cond_set_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_zero && alu_zero && pc_sel == 2'b00) |=> (pc_q == $past(alu_res)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_zero) |=> $stable(pc_q));
endmodule

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] alu_res = '0;
  logic        alu_zero = 1'b0;
  logic [25:0] jmp_field = '0;
  logic        pc_wr = 1'b0;
  logic        pc_wr_zero = 1'b0;
  logic        tgt_wr = 1'b0;
  logic [1:0]  pc_sel = 2'b00;
  logic [31:0] pc_q;

  item_t q_exp[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_pc = '0;
  logic [31:0] m_tgt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit dut_i (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_zero(alu_zero),
    .jmp_field(jmp_field), .pc_wr(pc_wr), .pc_wr_zero(pc_wr_zero),
    .tgt_wr(tgt_wr), .pc_sel(pc_sel), .pc_q(pc_q)
  );

  task automatic step(input logic r, input logic w, input logic wz,
                      input logic tw, input logic [1:0] s,
                      input logic [31:0] a, input logic z,
                      input logic [25:0] f, input string tag);
    logic [31:0] nxt;
    item_t it;
    @(negedge clk);
    rst = r; pc_wr = w; pc_wr_zero = wz; tgt_wr = tw; pc_sel = s;
    alu_res = a; alu_zero = z; jmp_field = f;
    case (s)
      2'b01:   nxt = m_tgt;
      2'b10:   nxt = {m_pc[31:28], f, 2'b00};
      default: nxt = a;
    endcase
    if (r) begin
      m_pc = '0; m_tgt = '0;
    end else begin
      if (w || (wz && z)) m_pc = nxt;
      if (tw) m_tgt = a;
    end
    it.exp = m_pc; it.tag = tag;
    q_exp.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        item_t it;
        it = q_exp.pop_front();
        checks++;
        if (pc_q !== it.exp) begin
          errors++;
          $display("FAIL %s: pc actual=%08h expected=%08h", it.tag, pc_q, it.exp);
        end
      end
    end
  end

  initial begin : driver
    step(1, 0, 0, 0, 2'b00, 32'hFFFF_FFFF, 1, 26'h3FF_FFFF, "R1");
    step(1, 1, 0, 1, 2'b00, 32'h1234_5678, 1, 26'h0, "R1");
    step(0, 1, 0, 0, 2'b01, 32'hDEAD_BEEF, 0, 26'h0, "R1");
    step(0, 1, 0, 0, 2'b00, 32'h0040_0004, 0, 26'h0, "R2");
    step(0, 0, 0, 1, 2'b00, 32'h0040_0100, 1, 26'h155_5555, "R8");
    step(0, 0, 0, 0, 2'b10, 32'h7777_0000, 1, 26'h2AA_AAAA, "R8");
    step(0, 1, 0, 0, 2'b01, 32'h0000_0044, 0, 26'h0, "R3");
    step(0, 1, 0, 0, 2'b00, 32'hA000_0010, 0, 26'h0, "R2");
    step(0, 1, 0, 0, 2'b10, 32'h0000_0000, 0, 26'h3FF_FFFF, "R4");
    step(0, 1, 0, 0, 2'b10, 32'h1111_1111, 1, 26'h012_3456, "R4");
    step(0, 1, 0, 0, 2'b11, 32'h1234_5678, 0, 26'h3FF_FFFF, "R5");
    step(0, 0, 1, 0, 2'b00, 32'h0000_2000, 1, 26'h0, "R6");
    step(0, 0, 1, 0, 2'b01, 32'h0000_3000, 1, 26'h0, "R6");
    step(0, 0, 1, 0, 2'b00, 32'h0000_4000, 0, 26'h0, "R7");
    step(0, 0, 1, 0, 2'b10, 32'h0000_5000, 0, 26'h3AB_CDEF, "R7");
    step(0, 1, 0, 0, 2'b00, 32'h0000_6000, 0, 26'h0, "R9");
    step(0, 1, 1, 0, 2'b00, 32'h0000_7000, 0, 26'h0, "R9");
    step(0, 0, 0, 1, 2'b00, 32'h0000_8000, 0, 26'h0, "R3");
    step(0, 1, 0, 1, 2'b01, 32'h0000_9000, 0, 26'h0, "R10");
    step(0, 1, 0, 0, 2'b01, 32'h0000_A000, 0, 26'h0, "R10");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (i + 1);
      step(0, v[3], v[7], v[11], v[13:12], v, v[17], v[31:6], "R2");
    end
    step(1, 1, 0, 0, 2'b00, 32'h5555_5555, 0, 26'h0, "R1");
    step(0, 1, 0, 0, 2'b01, 32'h0000_0000, 0, 26'h0, "R1");
    step(0, 0, 0, 0, 2'b00, 32'h0000_0000, 0, 26'h0, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule